// File: doc/BRIEF.md
# Two-Region Flash Erase Range Walker

This block turns a byte-range erase request into a series of single-block erase commands for a flash array. The array has two erase regions. The first region is made of small parameter blocks and starts at address zero. The second region is made of large main blocks and follows the first directly. A caller hands over a start address and a byte length. The block checks the request against the region table, which is held in parameters. If the request is sound, the block walks the range one block at a time. For each block it hands the block's address to an external erase engine and waits until the engine reports that block finished.

Alignment depends on the region. The start address must sit on a block boundary of the region it falls in. The end address must do the same for its own region. The walk moves by the small block size inside the first region and by the large block size once it has crossed into the second. One result is reported per request: completed, argument rejected, or erase failure. A block failure ends the walk at once.

Top module: `erase_walker`

## Requirements
- R1: The first region holds `R0_CNT` blocks of `R0_BLK` bytes starting at address 0, and the second holds `R1_CNT` blocks of `R1_BLK` bytes starting at `R0_CNT*R0_BLK`. The device size is the sum of both regions. The defaults are 8 blocks of 16 KiB and 31 blocks of 128 KiB. A request that covers exactly the whole device is accepted.
- R2: A request with nonzero length whose end (start plus length, computed without wrap-around) is greater than the device size is rejected. It reports code 1 and issues no erase command.
- R3: A request with nonzero length whose start is not a multiple of the block size of its region is rejected with code 1 and no erase. The start's region is the second one when start is at least the second region's offset, otherwise the first.
- R4: A request with nonzero length whose end is not a multiple of the block size of the region holding the end address is rejected with code 1 and no erase. That region is the second one when the end is at least the second region's offset.
- R5: An accepted request issues one erase command per block. The commands come in ascending order starting at the start address. Each step adds the block size of the region the current address lies in. The last command is the block just below the end address.
- R6: When the engine returns a failure for a block, no further command is issued and the result is code 2.
- R7: When every block erases without failure, the result is code 0.
- R8: A zero-length request reports code 0 and issues no erase command. No range or alignment check is applied to it.
- R9: `req_ready` is high only while idle, and a request is taken when `req_start` and `req_ready` are both high. `result_valid` is a single-cycle pulse. `ers_valid` stays high with a stable `ers_addr` until `ers_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe, taken while req_ready is high |
| req_addr | input | ADDR_W | Start byte address of the erase range |
| req_len | input | ADDR_W | Length of the erase range in bytes |
| req_ready | output | 1 | Walker idle and able to take a request |
| result_valid | output | 1 | One-cycle pulse carrying the request outcome |
| result_code | output | 2 | 0 completed, 1 argument rejected, 2 erase failure |
| ers_valid | output | 1 | Erase command outstanding to the engine |
| ers_addr | output | ADDR_W | Byte address of the block to erase |
| ers_ack | input | 1 | Engine finished the current block |
| ers_fail | input | 1 | Qualifies ers_ack: the block erase failed |

## Verification
The hardest case to reach is a walk that crosses the region boundary and then has a block fail after the crossing. Reaching it needs a start in the small-block region, an end aligned to a large block, and a failure placed at a chosen position in the sequence. The bench runs the walker with a tiny region table of 4×16 and 3×64 bytes. It sweeps every start and every length in 8-byte steps, which covers misaligned starts and ends in both regions as well as requests past the end. For some pairs it programs the responder to fail at a computed block index. The responder also varies its reply latency, so that the hold of the command under backpressure gets exercised.

// File: rtl/erase_walker_pkg.sv
// Shared types for the erase range walker: result codes and walker states.
package erase_walker_pkg;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_BADARG = 2'd1,
        RES_IOERR  = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ERASE,
        ST_REPORT
    } walk_st_e;

endpackage

// File: rtl/erase_region_lookup.sv
// Region lookup: returns the erase block size for a byte address.
// Assumes two regions, the second starting at R1_OFF, and power-of-two block sizes.
module erase_region_lookup #(
    parameter int AW1    = 23,
    parameter int R1_OFF = 131072,
    parameter int R0_BLK = 16384,
    parameter int R1_BLK = 131072
) (
    input  logic [AW1-1:0] addr,
    output logic [AW1-1:0] blk_size
);
    // Pick the block size of the region that holds addr.
    always_comb begin
        blk_size = (addr >= AW1'(R1_OFF)) ? AW1'(R1_BLK) : AW1'(R0_BLK);
    end
endmodule

// File: rtl/erase_req_check.sv
// Request validator: flags an empty request, or a request that runs past the device
// or whose start or end is off the block grid of its region.
// Assumes that start and length are zero-extended by one bit, so the sum cannot wrap.
module erase_req_check #(
    parameter int AW1    = 23,
    parameter int R1_OFF = 131072,
    parameter int R0_BLK = 16384,
    parameter int R1_BLK = 131072,
    parameter int TOTAL  = 4194304
) (
    input  logic [AW1-1:0] start_i,
    input  logic [AW1-1:0] len_i,
    output logic           empty_o,
    output logic           bad_o
);
    logic [AW1-1:0] end_a;
    logic [AW1-1:0] sz_start;
    logic [AW1-1:0] sz_end;

    // End address of the range.
    always_comb end_a = start_i + len_i;

    erase_region_lookup #(.AW1(AW1), .R1_OFF(R1_OFF), .R0_BLK(R0_BLK), .R1_BLK(R1_BLK))
        u_lk_start (.addr(start_i), .blk_size(sz_start));

    erase_region_lookup #(.AW1(AW1), .R1_OFF(R1_OFF), .R0_BLK(R0_BLK), .R1_BLK(R1_BLK))
        u_lk_end (.addr(end_a), .blk_size(sz_end));

    // Combine the range and the two alignment conditions.
    always_comb begin
        empty_o = (len_i == '0);
        bad_o   = (end_a > AW1'(TOTAL))
               || ((start_i & (sz_start - AW1'(1))) != '0)
               || ((end_a & (sz_end - AW1'(1))) != '0);
    end
endmodule

// File: rtl/erase_walk_step.sv
// Walk step: from the current address and the remaining byte count, computes the next
// address, the remaining count after this block, and whether this block is the last.
// Assumes that the second region's offset is a multiple of its block size.
module erase_walk_step #(
    parameter int AW1    = 23,
    parameter int R1_OFF = 131072,
    parameter int R0_BLK = 16384,
    parameter int R1_BLK = 131072
) (
    input  logic [AW1-1:0] cur_i,
    input  logic [AW1-1:0] rem_i,
    output logic [AW1-1:0] nxt_o,
    output logic [AW1-1:0] rem_nxt_o,
    output logic           last_o
);
    logic [AW1-1:0] step;

    erase_region_lookup #(.AW1(AW1), .R1_OFF(R1_OFF), .R0_BLK(R0_BLK), .R1_BLK(R1_BLK))
        u_lk_cur (.addr(cur_i), .blk_size(step));

    // Advance by the current region's block size.
    always_comb begin
        nxt_o     = cur_i + step;
        rem_nxt_o = rem_i - step;
        last_o    = (rem_i == step);
    end
endmodule

// File: rtl/erase_walker.sv
// Erase range walker: validates a byte-range erase request over a two-region flash and
// issues one erase command per block, held until the engine acknowledges it.
// Assumes power-of-two block sizes and one outstanding erase command at a time.
module erase_walker
    import erase_walker_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int R0_BLK = 16384,
    parameter int R0_CNT = 8,
    parameter int R1_BLK = 131072,
    parameter int R1_CNT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    output logic              req_ready,
    output logic              result_valid,
    output logic [1:0]        result_code,
    output logic              ers_valid,
    output logic [ADDR_W-1:0] ers_addr,
    input  logic              ers_ack,
    input  logic              ers_fail
);
    localparam int AW1    = ADDR_W + 1;
    localparam int R1_OFF = R0_BLK * R0_CNT;
    localparam int TOTAL  = R1_OFF + R1_BLK * R1_CNT;

    walk_st_e       st_q;
    res_e           code_q;
    logic [AW1-1:0] cur_q;
    logic [AW1-1:0] rem_q;
    logic           empty;
    logic           bad;
    logic [AW1-1:0] nxt;
    logic [AW1-1:0] rem_nxt;
    logic           last;

    erase_req_check #(.AW1(AW1), .R1_OFF(R1_OFF), .R0_BLK(R0_BLK),
                      .R1_BLK(R1_BLK), .TOTAL(TOTAL))
        u_check (.start_i(cur_q), .len_i(rem_q), .empty_o(empty), .bad_o(bad));

    erase_walk_step #(.AW1(AW1), .R1_OFF(R1_OFF), .R0_BLK(R0_BLK), .R1_BLK(R1_BLK))
        u_step (.cur_i(cur_q), .rem_i(rem_q), .nxt_o(nxt), .rem_nxt_o(rem_nxt), .last_o(last));

    // Walker sequencing: accept, validate, erase block by block, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= RES_OK;
            cur_q  <= '0;
            rem_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_start) begin
                        cur_q <= {1'b0, req_addr};
                        rem_q <= {1'b0, req_len};
                        st_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (empty) begin
                        code_q <= RES_OK;
                        st_q   <= ST_REPORT;
                    end else if (bad) begin
                        code_q <= RES_BADARG;
                        st_q   <= ST_REPORT;
                    end else begin
                        st_q <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (ers_ack) begin
                        if (ers_fail) begin
                            code_q <= RES_IOERR;
                            st_q   <= ST_REPORT;
                        end else begin
                            cur_q <= nxt;
                            rem_q <= rem_nxt;
                            if (last) begin
                                code_q <= RES_OK;
                                st_q   <= ST_REPORT;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the state and the held registers.
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        ers_valid    = (st_q == ST_ERASE);
        ers_addr     = cur_q[ADDR_W-1:0];
        result_valid = (st_q == ST_REPORT);
        result_code  = code_q;
    end
endmodule

// File: rtl/erase_walker_chk.sv
// Protocol and address checks for the erase range walker, attached by bind.
module erase_walker_chk #(
    parameter int ADDR_W = 22,
    parameter int R0_BLK = 16384,
    parameter int R0_CNT = 8,
    parameter int R1_BLK = 131072,
    parameter int R1_CNT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic              req_ready,
    input logic              result_valid,
    input logic [1:0]        result_code,
    input logic              ers_valid,
    input logic [ADDR_W-1:0] ers_addr,
    input logic              ers_ack,
    input logic              ers_fail
);
    localparam int R1_OFF = R0_BLK * R0_CNT;
    localparam int TOTAL  = R1_OFF + R1_BLK * R1_CNT;

    AST_ADDR_IN_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        ers_valid |-> ({1'b0, ers_addr} < (ADDR_W+1)'(TOTAL))); // R1

    AST_ADDR_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        ers_valid |-> ((ers_addr >= ADDR_W'(R1_OFF)) ? ((ers_addr % ADDR_W'(R1_BLK)) == '0)
                                                     : ((ers_addr % ADDR_W'(R0_BLK)) == '0))); // R5

    AST_STOP_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_valid && ers_ack && ers_fail) |=> (!ers_valid && result_valid && result_code == 2'd2)); // R6

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_valid && !ers_ack) |=> (ers_valid && $stable(ers_addr))); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R9

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_start) |=> !req_ready); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ers_valid && !result_valid)); // R9

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result_code != 2'd3)); // R7
endmodule

bind erase_walker erase_walker_chk #(
    .ADDR_W(ADDR_W), .R0_BLK(R0_BLK), .R0_CNT(R0_CNT), .R1_BLK(R1_BLK), .R1_CNT(R1_CNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_ready(req_ready),
    .result_valid(result_valid), .result_code(result_code), .ers_valid(ers_valid),
    .ers_addr(ers_addr), .ers_ack(ers_ack), .ers_fail(ers_fail)
);

// File: tb/erase_walker_bench.sv
// Sweep bench for the erase range walker on a tiny two-region table.
module erase_walker_bench;
    localparam int AW     = 12;
    localparam int B0     = 16;
    localparam int C0     = 4;
    localparam int B1     = 64;
    localparam int C1     = 3;
    localparam int R1OFF  = B0 * C0;
    localparam int TOTAL  = R1OFF + B1 * C1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] req_len = '0;
    logic          req_ready;
    logic          result_valid;
    logic [1:0]    result_code;
    logic          ers_valid;
    logic [AW-1:0] ers_addr;
    logic          ers_ack = 1'b0;
    logic          ers_fail = 1'b0;

    int total = 0;
    int bad_n = 0;
    bit finished = 0;

    int exp_addr [64];
    int exp_n;
    int fail_pos;
    int seen_cnt;
    int wait_cnt;
    bit addr_bad;
    int got_addr;
    int want_addr;

    always #10 clk = ~clk;

    erase_walker #(.ADDR_W(AW), .R0_BLK(B0), .R0_CNT(C0), .R1_BLK(B1), .R1_CNT(C1)) u_erase_walker (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr), .req_len(req_len),
        .req_ready(req_ready), .result_valid(result_valid), .result_code(result_code),
        .ers_valid(ers_valid), .ers_addr(ers_addr), .ers_ack(ers_ack), .ers_fail(ers_fail)
    );

    function automatic int blk_of(int a);
        return (a >= R1OFF) ? B1 : B0;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv, string what);
        total++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Erase engine stand-in: variable latency, checks each address, fails on request.
    initial begin
        seen_cnt = 0;
        wait_cnt = 0;
        addr_bad = 0;
        forever begin
            @(negedge clk);
            if (ers_ack) begin
                ers_ack  = 1'b0;
                ers_fail = 1'b0;
            end else if (ers_valid) begin
                if (wait_cnt == 0) begin
                    if (seen_cnt >= exp_n || int'(ers_addr) != exp_addr[seen_cnt]) begin
                        if (!addr_bad) begin
                            got_addr  = int'(ers_addr);
                            want_addr = (seen_cnt < exp_n) ? exp_addr[seen_cnt] : -1;
                        end
                        addr_bad = 1;
                    end
                    ers_fail = (seen_cnt == fail_pos);
                    ers_ack  = 1'b1;
                    seen_cnt++;
                    wait_cnt = (seen_cnt + int'(ers_addr) / 8) % 3;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // One request: model the result, drive it, compare code, command count and order.
    task automatic run_req(int start, int len, int fpos, string force_tag);
        int endv;
        int code_e;
        int n_issue;
        int a;
        int tmo;
        string tag;
        endv = start + len;
        exp_n = 0;
        if (len == 0) begin
            code_e = 0; tag = "R8";
        end else if (endv > TOTAL) begin
            code_e = 1; tag = "R2";
        end else if (start % blk_of(start) != 0) begin
            code_e = 1; tag = "R3";
        end else if (endv % blk_of(endv) != 0) begin
            code_e = 1; tag = "R4";
        end else begin
            a = start;
            while (a < endv) begin
                exp_addr[exp_n] = a;
                exp_n++;
                a += blk_of(a);
            end
            if (fpos < exp_n) begin
                code_e = 2; tag = "R6";
            end else begin
                code_e = 0; tag = "R7";
            end
        end
        n_issue = (code_e == 1) ? 0 : ((code_e == 2) ? fpos + 1 : exp_n);
        if (force_tag != "") tag = force_tag;
        fail_pos = fpos;
        seen_cnt = 0;
        addr_bad = 0;
        wait_cnt = (start / 8) % 3;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = AW'(start);
        req_len   = AW'(len);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (start % 56 == 0) check(req_ready == 1'b0, "R9", int'(req_ready), 0, "ready while busy");
        tmo = 0;
        while (!result_valid && tmo < 500) begin
            @(negedge clk);
            tmo++;
        end
        check(int'(result_code) == code_e && result_valid, tag, int'(result_code), code_e, "result code");
        check(seen_cnt == n_issue, tag, seen_cnt, n_issue, "erase command count");
        if (exp_n > 0) check(!addr_bad, "R5", got_addr, want_addr, "erase address order");
        @(negedge clk);
        if (start % 56 == 0) check(result_valid == 1'b0, "R9", int'(result_valid), 0, "result pulse width");
    endtask

    initial begin
        exp_n = 0;
        fail_pos = 99;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R9", int'(req_ready), 1, "reset ready");
        check(ers_valid == 1'b0, "R9", int'(ers_valid), 0, "reset erase valid");
        check(result_valid == 1'b0, "R9", int'(result_valid), 0, "reset result");
        // R1: whole device accepted, one byte-block beyond rejected
        run_req(0, TOTAL, 99, "R1");
        run_req(0, TOTAL + 16, 99, "R2");
        // R2: sum past the address width must not wrap
        run_req((1 << AW) - 8, 16, 99, "R2");
        // R6: failure right after crossing into the second region
        run_req(32, 96, 2, "R6");
        // R8: empty request with misaligned start
        run_req(4, 0, 0, "R8");
        // Sweep over starts and lengths on an 8-byte grid.
        for (int s = 0; s <= TOTAL + 16; s += 8) begin
            for (int l = 0; l <= TOTAL + 16; l += 8) begin
                int fp;
                fp = (((s / 8) + (l / 8)) % 7 == 0) ? (s / 8) % 3 : 99;
                run_req(s, l, fp, "");
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad_n++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad_n);
            $finish;
        end
    end
endmodule